// File: doc/BRIEF.md
# CAN Node Fault Confinement Counters

This block holds the transmit and receive error counters of a CAN node and works out the node's fault confinement state from them. The protocol engine drives it with single-cycle event strobes and a few qualifiers. The strobes are: error detected, error flag completed, dominant bit after the node's own flag, bit error while a flag is being sent, dominant-run milestone, transmit success and receive success. The qualifiers give the node's role (transmitter or receiver), the ACK-error and arbitration stuff-error exceptions, and whether the bus is in intermission.

An error that is detected is not counted at once. It is stored as a pending penalty, together with the role, the exception qualifiers and the error-passive state at that moment. The penalty is applied when the engine reports that the error flag has been sent. The receive count is a 7-bit field with a separate passive flag. When a passive receiver completes a good reception, the field is reloaded with a fixed value between 119 and 127 and the passive flag is cleared. Bus-off is sticky until reset, and every count is frozen while the node is bus-off.

Top module: `can_fault_counters`

## Requirements
- R1: A synchronous active-high reset clears the transmit count, the receive field and the passive flag. After reset the node reports error-active, and the overload request is low.
- R2: `ev_err` with `role_tx`=0 outside intermission does not change the counts in that cycle. The next `ev_flag_done` adds 1 to the receive field.
- R3: `ev_err` with `role_tx`=1 followed by `ev_flag_done` adds 8 to the transmit count, with two exceptions. No change occurs if `err_stuff_arb` was set at detection. No change occurs if `err_ack` was set and the node was error-passive at detection, and `flag_dom_seen` is 0 at `ev_flag_done`. The passive test uses the state at detection, not the state at flag completion.
- R4: `ev_dom_after_flag` with `role_tx`=0 adds 8 to the receive field.
- R5: `ev_flag_bit_err` adds 8 to the counter of the current role only while the node is error-active. It has no effect while the node is error-passive.
- R6: `ev_dom_run` adds 8 to the counter of the current role.
- R7: `ev_tx_ok` lowers the transmit count by 1. It has no effect at 0.
- R8: When the passive flag is clear, `ev_rx_ok` lowers the receive field by 1, and it has no effect at 0. When the passive flag is set, `ev_rx_ok` loads the field with `RX_RELOAD` (default 120) and clears the flag.
- R9: An increment that would carry the receive field past 127 sets the passive flag and holds the field at 127. Further increments keep it at 127.
- R10: The state is error-active when the transmit count is below 128 and the passive flag is clear. It is error-passive otherwise, unless the node is bus-off. An increment that would take the transmit count past 255 enters bus-off and leaves the count at 255. Bus-off freezes all counts until reset.
- R11: `ev_err` while `in_intermission`=1 leaves both counts unchanged and queues no penalty. It raises `ovl_req` for exactly one cycle, in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| role_tx | input | 1 | 1 = node is transmitter, 0 = receiver |
| ev_err | input | 1 | Error detected (strobe) |
| err_ack | input | 1 | Qualifier: the detected error is an ACK error |
| err_stuff_arb | input | 1 | Qualifier: stuff error in the arbitration field on a recessive stuff bit |
| in_intermission | input | 1 | Qualifier: the bus is in intermission |
| ev_flag_done | input | 1 | Error flag fully sent (strobe) |
| flag_dom_seen | input | 1 | A dominant bit was seen during the passive flag |
| ev_dom_after_flag | input | 1 | Dominant bit right after own error flag (strobe) |
| ev_flag_bit_err | input | 1 | Bit error while sending an active error or overload flag (strobe) |
| ev_dom_run | input | 1 | Dominant-run milestone reached (strobe) |
| ev_tx_ok | input | 1 | Transmission finished without error (strobe) |
| ev_rx_ok | input | 1 | Reception finished without error (strobe) |
| tec | output | 8 | Transmit error count |
| rec | output | 7 | Receive error field |
| rec_passive | output | 1 | Receive passive flag |
| st_active | output | 1 | Node is error-active |
| st_passive | output | 1 | Node is error-passive |
| st_busoff | output | 1 | Node is bus-off |
| ovl_req | output | 1 | Overload frame request (one-cycle pulse) |

## Verification
The assertions check, on every cycle, that the receive field stays pinned at 127 while the passive flag is set and that bus-off stays set with a frozen transmit count. They also check the single-step decrement, the reload on a passive reception and the overload pulse. Only the bench scenarios can show the deferred application of penalties. The same applies to the exception cases decided from the state at detection, and to the combined paths through error-passive into bus-off.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
    localparam int TEC_W    = 8;
    localparam int REC_W    = 7;
    localparam int INC_W    = 6;
    localparam int STEP_BIG = 8;
    localparam int TEC_PASS = 128;

    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_PASSIVE = 2'd1,
        FC_BUSOFF  = 2'd2
    } fc_state_e;

    typedef struct packed {
        logic valid;
        logic tx;
        logic ack_pas;
        logic stuff;
    } pend_t;

    function automatic fc_state_e fc_state(input logic [TEC_W-1:0] t,
                                           input logic rpas,
                                           input logic boff);
        if (boff)
            return FC_BUSOFF;
        else if (rpas || (int'(t) >= TEC_PASS))
            return FC_PASSIVE;
        else
            return FC_ACTIVE;
    endfunction
endpackage

// File: rtl/fcc_pending.sv
module fcc_pending
    import fcc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic role_tx,
    input  logic passive_now,
    input  logic ev_err,
    input  logic err_ack,
    input  logic err_stuff_arb,
    input  logic in_intermission,
    input  logic ev_flag_done,
    input  logic flag_dom_seen,
    output logic add_tx8,
    output logic add_rx1,
    output logic ovl_req
);
    pend_t pend_q;
    logic  skip;

    always_comb begin
        skip    = pend_q.stuff || (pend_q.ack_pas && !flag_dom_seen);
        add_tx8 = ev_flag_done && pend_q.valid && pend_q.tx && !skip;
        add_rx1 = ev_flag_done && pend_q.valid && !pend_q.tx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            ovl_req <= 1'b0;
        end else begin
            ovl_req <= ev_err && in_intermission;
            if (ev_err && !in_intermission) begin
                pend_q.valid   <= 1'b1;
                pend_q.tx      <= role_tx;
                pend_q.ack_pas <= err_ack && passive_now;
                pend_q.stuff   <= err_stuff_arb;
            end else if (ev_flag_done) begin
                pend_q <= '0;
            end
        end
    end

    a_r11_ovl_pulse: assert property (@(posedge clk) disable iff (rst)
        ev_err && in_intermission |=> ovl_req);
    a_r2_pending_kept: assert property (@(posedge clk) disable iff (rst)
        ev_err && !in_intermission |=> pend_q.valid);
endmodule

// File: rtl/fcc_tx_counter.sv
module fcc_tx_counter
    import fcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [INC_W-1:0] inc,
    input  logic             dec,
    output logic [TEC_W-1:0] cnt,
    output logic             busoff
);
    logic [TEC_W:0] sum;

    always_comb sum = {1'b0, cnt} + (TEC_W+1)'(inc);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            busoff <= 1'b0;
        end else if (!busoff) begin
            if (inc != '0) begin
                if (sum[TEC_W]) begin
                    busoff <= 1'b1;
                    cnt    <= '1;
                end else begin
                    cnt <= sum[TEC_W-1:0];
                end
            end else if (dec && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    a_r7_tx_step_down: assert property (@(posedge clk) disable iff (rst)
        !busoff && dec && inc == '0 && cnt != '0 |=> cnt == $past(cnt) - 1'b1);
    a_r10_busoff_sticky: assert property (@(posedge clk) disable iff (rst)
        busoff |=> busoff && $stable(cnt));
endmodule

// File: rtl/fcc_rx_counter.sv
module fcc_rx_counter
    import fcc_pkg::*;
#(
    parameter logic [REC_W-1:0] RX_RELOAD = 7'd120
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             freeze,
    input  logic [INC_W-1:0] inc,
    input  logic             ok,
    output logic [REC_W-1:0] field,
    output logic             passive
);
    logic [REC_W:0] sum;

    always_comb sum = {1'b0, field} + (REC_W+1)'(inc);

    always_ff @(posedge clk) begin
        if (rst) begin
            field   <= '0;
            passive <= 1'b0;
        end else if (!freeze) begin
            if (inc != '0) begin
                if (passive || sum[REC_W]) begin
                    passive <= 1'b1;
                    field   <= '1;
                end else begin
                    field <= sum[REC_W-1:0];
                end
            end else if (ok) begin
                if (passive) begin
                    passive <= 1'b0;
                    field   <= RX_RELOAD;
                end else if (field != '0) begin
                    field <= field - 1'b1;
                end
            end
        end
    end

    a_r9_pinned_at_top: assert property (@(posedge clk) disable iff (rst)
        passive |-> field == '1);
    a_r8_reload: assert property (@(posedge clk) disable iff (rst)
        passive && ok && inc == '0 && !freeze |=> !passive && field == RX_RELOAD);
endmodule

// File: rtl/can_fault_counters.sv
module can_fault_counters
    import fcc_pkg::*;
#(
    parameter logic [REC_W-1:0] RX_RELOAD = 7'd120
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             role_tx,
    input  logic             ev_err,
    input  logic             err_ack,
    input  logic             err_stuff_arb,
    input  logic             in_intermission,
    input  logic             ev_flag_done,
    input  logic             flag_dom_seen,
    input  logic             ev_dom_after_flag,
    input  logic             ev_flag_bit_err,
    input  logic             ev_dom_run,
    input  logic             ev_tx_ok,
    input  logic             ev_rx_ok,
    output logic [TEC_W-1:0] tec,
    output logic [REC_W-1:0] rec,
    output logic             rec_passive,
    output logic             st_active,
    output logic             st_passive,
    output logic             st_busoff,
    output logic             ovl_req
);
    fc_state_e        state;
    logic             busoff;
    logic             add_tx8, add_rx1, fbe_ok;
    logic [INC_W-1:0] tx_inc, rx_inc;

    always_comb begin
        state      = fc_state(tec, rec_passive, busoff);
        st_active  = (state == FC_ACTIVE);
        st_passive = (state == FC_PASSIVE);
        st_busoff  = (state == FC_BUSOFF);
        fbe_ok     = ev_flag_bit_err && st_active;
        tx_inc = INC_W'(STEP_BIG) * (INC_W'(add_tx8)
                 + INC_W'(role_tx && fbe_ok) + INC_W'(role_tx && ev_dom_run));
        rx_inc = INC_W'(add_rx1) + INC_W'(STEP_BIG) * (
                   INC_W'(!role_tx && ev_dom_after_flag)
                 + INC_W'(!role_tx && fbe_ok) + INC_W'(!role_tx && ev_dom_run));
    end

    fcc_pending u_pend (
        .clk(clk), .rst(rst), .role_tx(role_tx), .passive_now(st_passive),
        .ev_err(ev_err), .err_ack(err_ack), .err_stuff_arb(err_stuff_arb),
        .in_intermission(in_intermission), .ev_flag_done(ev_flag_done),
        .flag_dom_seen(flag_dom_seen), .add_tx8(add_tx8), .add_rx1(add_rx1),
        .ovl_req(ovl_req)
    );

    fcc_tx_counter u_tx (
        .clk(clk), .rst(rst), .inc(tx_inc), .dec(ev_tx_ok),
        .cnt(tec), .busoff(busoff)
    );

    fcc_rx_counter #(.RX_RELOAD(RX_RELOAD)) u_rx (
        .clk(clk), .rst(rst), .freeze(busoff), .inc(rx_inc), .ok(ev_rx_ok),
        .field(rec), .passive(rec_passive)
    );

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> tec == '0 && rec == '0 && !rec_passive && !ovl_req);
    a_r10_passive_tec: assert property (@(posedge clk) disable iff (rst)
        int'(tec) >= TEC_PASS |-> !st_active);
    a_r5_no_fbe_passive: assert property (@(posedge clk) disable iff (rst)
        st_passive && ev_flag_bit_err && !ev_dom_run && !ev_dom_after_flag
        && !ev_flag_done && !role_tx |=> rec == $past(rec));
endmodule

// File: tb/test_can_fault_counters.sv
module test_can_fault_counters;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic role_tx, ev_err, err_ack, err_stuff_arb, in_intermission, ev_flag_done;
    logic flag_dom_seen, ev_dom_after_flag, ev_flag_bit_err, ev_dom_run, ev_tx_ok, ev_rx_ok;
    logic [7:0] tec;
    logic [6:0] rec;
    logic rec_passive, st_active, st_passive, st_busoff, ovl_req;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    can_fault_counters i_can_fault_counters (
        .clk(clk), .rst(rst), .role_tx(role_tx), .ev_err(ev_err), .err_ack(err_ack),
        .err_stuff_arb(err_stuff_arb), .in_intermission(in_intermission),
        .ev_flag_done(ev_flag_done), .flag_dom_seen(flag_dom_seen),
        .ev_dom_after_flag(ev_dom_after_flag), .ev_flag_bit_err(ev_flag_bit_err),
        .ev_dom_run(ev_dom_run), .ev_tx_ok(ev_tx_ok), .ev_rx_ok(ev_rx_ok),
        .tec(tec), .rec(rec), .rec_passive(rec_passive), .st_active(st_active),
        .st_passive(st_passive), .st_busoff(st_busoff), .ovl_req(ovl_req)
    );

    // event bits: 11 role_tx, 10 err, 9 ack, 8 stuff, 7 intermission, 6 flag_done,
    // 5 dom_seen, 4 dom_after_flag, 3 flag_bit_err, 2 dom_run, 1 tx_ok, 0 rx_ok
    localparam logic [11:0] E_IDLE   = 12'b0000_0000_0000;
    localparam logic [11:0] E_DOMRX  = 12'b0000_0001_0000;
    localparam logic [11:0] E_RUNTX  = 12'b1000_0000_0100;
    localparam logic [11:0] E_TXOK   = 12'b0000_0000_0010;
    localparam logic [11:0] E_RXOK   = 12'b0000_0000_0001;
    localparam logic [11:0] E_ACKTX  = 12'b1110_0000_0000;
    localparam logic [11:0] E_DONETX = 12'b1000_0100_0000;
    localparam logic [11:0] E_DONEDS = 12'b1000_0110_0000;
    localparam logic [11:0] E_FBETX  = 12'b1000_0000_1000;
    localparam logic [11:0] E_INTERR = 12'b0100_1000_0000;

    localparam int NV = 16;
    // {events, expected tec, expected rec, expected passive}
    localparam logic [27:0] VEC [NV] = '{
        {12'b0100_0000_0000, 8'd0,  7'd0,  1'b0},  // R2 rx error pending
        {12'b0000_0100_0000, 8'd0,  7'd1,  1'b0},  // R2 applied at flag done
        {12'b0000_0001_0000, 8'd0,  7'd9,  1'b0},  // R4
        {12'b0000_0000_0100, 8'd0,  7'd17, 1'b0},  // R6 rx role
        {12'b0000_0000_0001, 8'd0,  7'd16, 1'b0},  // R8 decrement
        {12'b1100_0000_0000, 8'd0,  7'd16, 1'b0},  // R3 tx error pending
        {12'b1000_0100_0000, 8'd8,  7'd16, 1'b0},  // R3 +8
        {12'b1101_0000_0000, 8'd8,  7'd16, 1'b0},  // R3 stuff in arbitration
        {12'b1000_0100_0000, 8'd8,  7'd16, 1'b0},  // R3 stuff exception
        {12'b1000_0000_1000, 8'd16, 7'd16, 1'b0},  // R5 active
        {12'b1000_0000_0100, 8'd24, 7'd16, 1'b0},  // R6 tx role
        {12'b0000_0000_0010, 8'd23, 7'd16, 1'b0},  // R7
        {12'b1110_0000_0000, 8'd23, 7'd16, 1'b0},  // R3 ack while active
        {12'b1000_0100_0000, 8'd31, 7'd16, 1'b0},  // R3 ack not excepted
        {12'b0100_1000_0000, 8'd31, 7'd16, 1'b0},  // R11 intermission
        {12'b0000_0100_0000, 8'd31, 7'd16, 1'b0}   // R11 nothing queued
    };

    task automatic drive(input logic [11:0] e);
        {role_tx, ev_err, err_ack, err_stuff_arb, in_intermission, ev_flag_done,
         flag_dom_seen, ev_dom_after_flag, ev_flag_bit_err, ev_dom_run, ev_tx_ok, ev_rx_ok} = e;
        @(posedge clk);
        #1;
        {role_tx, ev_err, err_ack, err_stuff_arb, in_intermission, ev_flag_done,
         flag_dom_seen, ev_dom_after_flag, ev_flag_bit_err, ev_dom_run, ev_tx_ok, ev_rx_ok} = E_IDLE;
    endtask

    task automatic chk(input string req, input logic [7:0] et, input logic [6:0] er,
                       input logic ep);
        checks++;
        if (tec !== et || rec !== er || rec_passive !== ep) begin
            errors++;
            $display("FAIL %s: tec=%0d rec=%0d pas=%0b expected tec=%0d rec=%0d pas=%0b",
                     req, tec, rec, rec_passive, et, er, ep);
        end
    endtask

    task automatic chk_st(input string req, input logic [2:0] exp_st);
        checks++;
        if ({st_active, st_passive, st_busoff} !== exp_st) begin
            errors++;
            $display("FAIL %s: state(a,p,b)=%b expected %b", req,
                     {st_active, st_passive, st_busoff}, exp_st);
        end
    endtask

    task automatic chk_ovl(input string req, input logic exp);
        checks++;
        if (ovl_req !== exp) begin
            errors++;
            $display("FAIL %s: ovl_req=%b expected %b", req, ovl_req, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        drive(E_IDLE);
        rst = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        {role_tx, ev_err, err_ack, err_stuff_arb, in_intermission, ev_flag_done,
         flag_dom_seen, ev_dom_after_flag, ev_flag_bit_err, ev_dom_run, ev_tx_ok, ev_rx_ok} = E_IDLE;
        do_reset();
        chk("R1 reset", 8'd0, 7'd0, 1'b0);
        chk_st("R1 reset state", 3'b100);
        chk_ovl("R1 reset ovl", 1'b0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][27:16]);
            chk($sformatf("vector %0d", i), VEC[i][15:8], VEC[i][7:1], VEC[i][0]);
        end

        // R11 overload pulse
        do_reset();
        drive(E_INTERR);
        chk_ovl("R11 pulse high", 1'b1);
        drive(E_IDLE);
        chk_ovl("R11 pulse one cycle", 1'b0);
        chk("R11 counts", 8'd0, 7'd0, 1'b0);

        // R7 / R8 floors
        drive(E_TXOK);
        chk("R7 floor", 8'd0, 7'd0, 1'b0);
        drive(E_RXOK);
        chk("R8 floor", 8'd0, 7'd0, 1'b0);

        // R9 receive passive saturation
        for (int k = 0; k < 16; k++) drive(E_DOMRX);
        chk("R9 enter passive", 8'd0, 7'd127, 1'b1);
        chk_st("R10 rx passive", 3'b010);
        drive(E_DOMRX);
        chk("R9 hold at top", 8'd0, 7'd127, 1'b1);
        drive(E_RXOK);
        chk("R8 reload", 8'd0, 7'd120, 1'b0);
        chk_st("R8 back active", 3'b100);

        // transmit passive region
        do_reset();
        for (int k = 0; k < 16; k++) drive(E_RUNTX);
        chk("R6 tec to 128", 8'd128, 7'd0, 1'b0);
        chk_st("R10 tx passive", 3'b010);
        drive(E_FBETX);
        chk("R5 ignored when passive", 8'd128, 7'd0, 1'b0);
        drive(E_ACKTX);
        drive(E_DONETX);
        chk("R3 ack exception passive", 8'd128, 7'd0, 1'b0);
        drive(E_ACKTX);
        drive(E_DONEDS);
        chk("R3 ack with dominant seen", 8'd136, 7'd0, 1'b0);
        for (int k = 0; k < 8; k++) drive(E_TXOK);
        chk("R7 down to 128", 8'd128, 7'd0, 1'b0);
        drive(E_ACKTX);
        drive(E_TXOK);
        chk_st("R10 active at 127", 3'b100);
        drive(E_DONETX);
        chk("R3 state at detection", 8'd127, 7'd0, 1'b0);

        // R10 bus-off
        for (int k = 0; k < 16; k++) drive(E_RUNTX);
        chk("R10 tec 255 passive", 8'd255, 7'd0, 1'b0);
        drive(E_RUNTX);
        chk("R10 bus-off saturate", 8'd255, 7'd0, 1'b0);
        chk_st("R10 bus-off state", 3'b001);
        drive(E_TXOK);
        drive(E_DOMRX);
        chk("R10 frozen", 8'd255, 7'd0, 1'b0);
        chk_st("R10 still bus-off", 3'b001);

        do_reset();
        chk("R1 reset from bus-off", 8'd0, 7'd0, 1'b0);
        chk_st("R1 active after reset", 3'b100);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule